// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out the atomic memory instructions of a 64-bit register machine. The decode stage hands it the opcode byte, the 32-bit immediate, the 16-bit offset and three register values: the base (destination) register, the operand (source) register and R0. The unit forms the effective address, reads memory once, computes the new value and, if the operation calls for it, writes once. It then reports a single-cycle completion together with an optional register writeback.

The immediate selects the operation. Add, OR, AND and XOR reuse the arithmetic operation codes. Exchange and compare-exchange have codes of their own. The low immediate bit asks for the prior memory contents to be returned. Compare-exchange always returns the prior contents into R0 instead of the source register. The memory port stays owned by the unit from the read until completion, so no other access can fall between the read and the write.

Top module: `amo_unit`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `wb_en` and `mem_req` are all low.
- R2: Only opcode 0xc3 (32-bit) and 0xdb (64-bit) are accepted. Any other opcode, including the byte form 0xd3 and the halfword form 0xcb, produces a one-cycle `illegal` pulse in the cycle after `start`. It causes no memory access and no `done`.
- R3: The memory address is the base register plus the sign-extended 16-bit offset, truncated to `ADDR_W` bits.
- R4: An accepted operation issues exactly one read, then at most one write. `done` is high for exactly one cycle, four clocks after the `start` edge. `busy` stays high from acceptance through `done`.
- R5: Immediate 0x00 adds, 0x40 ORs, 0x50 ANDs and 0xa0 XORs the source value into memory.
- R6: Immediate bit 0 (fetch) set: at `done`, `wb_en` is high, `wb_r0` is low and `wb_data` holds the prior memory value. Fetch clear: `wb_en` stays low.
- R7: Immediate 0xe1 (exchange) writes the source value to memory and returns the prior value to the source register.
- R8: Immediate 0xf1 (compare-exchange) writes the source value only when memory equals R0, and skips the write otherwise. In both cases it returns the prior value with `wb_r0` high.
- R9: Any immediate outside {0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1, 0xf1} is illegal, as R2 describes. This includes 0xe0 and 0xf0.
- R10: In 32-bit form, `mem_wide` is low and only `mem_wdata[31:0]` carries the result, taken modulo 2^32. Compare-exchange compares only the low 32 bits, and the returned value is zero-extended.
- R11: A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid, sampled while idle |
| op_code | input | 8 | Opcode byte |
| imm | input | 32 | Immediate, selects operation |
| off | input | 16 | Signed address offset |
| dst_val | input | 64 | Base register value |
| src_val | input | 64 | Operand register value |
| r0_val | input | 64 | R0 value, compare-exchange expectation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-encoding pulse |
| wb_en | output | 1 | Register writeback valid, with done |
| wb_r0 | output | 1 | Writeback goes to R0 rather than source register |
| wb_data | output | 64 | Prior memory value, zero-extended |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is 64-bit (else 32-bit) |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
The bench builds the unit with `ADDR_W` = 8, so a 32-entry memory of 64-bit words covers the whole address space. Negative offsets then wrap onto real locations. Eight address bits also let one word be split into two 32-bit halves by address bit 2, so the bench can check that a 32-bit access leaves the other half of the word untouched.

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        op_code,
  input  logic [31:0]       imm,
  input  logic [15:0]       off,
  input  logic [63:0]       dst_val,
  input  logic [63:0]       src_val,
  input  logic [63:0]       r0_val,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              wb_en,
  output logic              wb_r0,
  output logic [63:0]       wb_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_MOD, S_WR, S_DONE} st_t;

  st_t              st;
  logic             wide_q, wr_q, ill_q;
  logic [7:0]       fn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [63:0]      src_q, r0_q, old_q, new_q;

  logic        op_ok, imm_ok, accept;
  logic [63:0] ea, rd_v, sv, r0v, res, res_w;
  logic        cmp_hit;

  assign op_ok = (op_code == 8'hc3) || (op_code == 8'hdb);
  always_comb begin
    case (imm)
      32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
      32'ha0, 32'ha1, 32'he1, 32'hf1: imm_ok = 1'b1;
      default:                        imm_ok = 1'b0;
    endcase
  end
  assign accept = (st == S_IDLE) && start;
  assign ea     = dst_val + {{48{off[15]}}, off};

  assign rd_v    = wide_q ? mem_rdata : {32'b0, mem_rdata[31:0]};
  assign sv      = wide_q ? src_q : {32'b0, src_q[31:0]};
  assign r0v     = wide_q ? r0_q : {32'b0, r0_q[31:0]};
  assign cmp_hit = (rd_v == r0v);

  always_comb begin
    case (fn_q[7:4])
      4'h0:    res = rd_v + sv;
      4'h4:    res = rd_v | sv;
      4'h5:    res = rd_v & sv;
      4'ha:    res = rd_v ^ sv;
      default: res = sv;
    endcase
  end
  assign res_w = wide_q ? res : {32'b0, res[31:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ill_q  <= 1'b0;
      wide_q <= 1'b0;
      wr_q   <= 1'b0;
      fn_q   <= 8'h0;
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
      old_q  <= '0;
      new_q  <= '0;
    end else begin
      ill_q <= accept && !(op_ok && imm_ok);
      case (st)
        S_IDLE: if (start && op_ok && imm_ok) begin
          st     <= S_RD;
          wide_q <= op_code[4];
          fn_q   <= imm[7:0];
          addr_q <= ea[ADDR_W-1:0];
          src_q  <= src_val;
          r0_q   <= r0_val;
        end
        S_RD:  st <= S_MOD;
        S_MOD: begin
          old_q <= rd_v;
          new_q <= res_w;
          wr_q  <= (fn_q[7:4] != 4'hf) || cmp_hit;
          st    <= S_WR;
        end
        S_WR:    st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign illegal   = ill_q;
  assign wb_en     = done && fn_q[0];
  assign wb_r0     = (fn_q[7:4] == 4'hf);
  assign wb_data   = old_q;
  assign mem_req   = (st == S_RD) || ((st == S_WR) && wr_q);
  assign mem_we    = (st == S_WR) && wr_q;
  assign mem_wide  = wide_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              wb_en,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_illegal_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);
  p_illegal_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req && !done);
  p_wb_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  p_idle_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req && !mem_we);
  p_done_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

bind amo_unit amo_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .wb_en(wb_en), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] op_code = '0;
  logic [31:0] imm = '0;
  logic [15:0] off = '0;
  logic [63:0] dst_val = '0, src_val = '0, r0_val = '0;
  logic busy, done, illegal, wb_en, wb_r0, mem_req, mem_we, mem_wide;
  logic [63:0] wb_data, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  logic [63:0] mem [32];
  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0, dn_cnt = 0, il_cnt = 0, lat = 0;
  logic c_en, c_r0;
  logic [63:0] c_data;

  always #10ns clk = ~clk;

  amo_unit #(.ADDR_W(AW)) u0 (.*);

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        wr_cnt++;
        if (mem_wide) mem[mem_addr[7:3]] <= mem_wdata;
        else if (mem_addr[2]) mem[mem_addr[7:3]][63:32] <= mem_wdata[31:0];
        else mem[mem_addr[7:3]][31:0] <= mem_wdata[31:0];
      end else begin
        rd_cnt++;
        if (mem_wide) mem_rdata <= mem[mem_addr[7:3]];
        else if (mem_addr[2]) mem_rdata <= {32'b0, mem[mem_addr[7:3]][63:32]};
        else mem_rdata <= {32'b0, mem[mem_addr[7:3]][31:0]};
      end
    end
  end

  always @(negedge clk) begin
    if (done) dn_cnt++;
    if (illegal) il_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [31:0] im, input logic [15:0] of,
                        input logic [63:0] d, input logic [63:0] s, input logic [63:0] r);
    @(negedge clk);
    op_code = op; imm = im; off = of; dst_val = d; src_val = s; r0_val = r;
    rd_cnt = 0; wr_cnt = 0; dn_cnt = 0; il_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && !illegal && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    c_en = wb_en; c_r0 = wb_r0; c_data = wb_data;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busy", {63'b0, busy}, 64'd0);
    chk("R1 done", {63'b0, done}, 64'd0);
    chk("R1 illegal", {63'b0, illegal}, 64'd0);
    chk("R1 wb_en", {63'b0, wb_en}, 64'd0);
    chk("R1 mem_req", {63'b0, mem_req}, 64'd0);
  endtask

  task automatic t_add64;
    mem[2] = 64'h0000_0001_FFFF_FFFF;
    run_op(8'hdb, 32'h01, 16'hFFF0, 64'h20, 64'd1, 64'd0);
    chk("R5 R3 add64 mem", mem[2], 64'h0000_0002_0000_0000);
    chk("R6 add64 wb_en", {63'b0, c_en}, 64'd1);
    chk("R6 add64 wb_r0", {63'b0, c_r0}, 64'd0);
    chk("R6 add64 wb_data", c_data, 64'h0000_0001_FFFF_FFFF);
    chk("R4 latency", 64'(lat), 64'd4);
    chk("R4 reads", 64'(rd_cnt), 64'd1);
    chk("R4 writes", 64'(wr_cnt), 64'd1);
    chk("R4 done width", 64'(dn_cnt), 64'd1);
  endtask

  task automatic t_logic;
    mem[3] = 64'hF0F0_0000_0000_000F;
    run_op(8'hdb, 32'h40, 16'h0000, 64'h18, 64'h0F00_0000_0000_00F0, 64'd0);
    chk("R5 or64 mem", mem[3], 64'hFFF0_0000_0000_00FF);
    chk("R6 or64 no fetch", {63'b0, c_en}, 64'd0);
    mem[4] = 64'hFFFF_0000_FFFF_0000;
    run_op(8'hdb, 32'h51, 16'h0010, 64'h10, 64'h0FF0_0FF0_0FF0_0FF0, 64'd0);
    chk("R5 and64 mem", mem[4], 64'h0FF0_0000_0FF0_0000);
    chk("R6 and64 wb", c_data, 64'hFFFF_0000_FFFF_0000);
    mem[5] = 64'h1111_1111_2222_2222;
    run_op(8'hc3, 32'ha1, 16'h0000, 64'h28, 64'hDEAD_BEEF_0000_FFFF, 64'd0);
    chk("R5 R10 xor32 mem", mem[5], 64'h1111_1111_2222_DDDD);
    chk("R10 xor32 wb", c_data, 64'h0000_0000_2222_2222);
  endtask

  task automatic t_word32;
    mem[1] = 64'hFFFF_FFFF_1234_5678;
    run_op(8'hc3, 32'h01, 16'h0004, 64'h08, 64'hAAAA_AAAA_0000_0001, 64'd0);
    chk("R10 add32 wrap", mem[1], 64'h0000_0000_1234_5678);
    chk("R10 add32 zext wb", c_data, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_xchg;
    mem[6] = 64'h0123_4567_89AB_CDEF;
    run_op(8'hdb, 32'he1, 16'h0000, 64'h30, 64'hCAFE_F00D_0000_1234, 64'd0);
    chk("R7 xchg mem", mem[6], 64'hCAFE_F00D_0000_1234);
    chk("R7 xchg wb", c_data, 64'h0123_4567_89AB_CDEF);
    chk("R7 xchg to src", {62'b0, c_en, c_r0}, 64'd2);
  endtask

  task automatic t_cmpxchg;
    mem[7] = 64'h55;
    run_op(8'hdb, 32'hf1, 16'h0000, 64'h38, 64'h99, 64'h55);
    chk("R8 cas hit mem", mem[7], 64'h99);
    chk("R8 cas hit wb", c_data, 64'h55);
    chk("R8 cas to r0", {63'b0, c_r0}, 64'd1);
    run_op(8'hdb, 32'hf1, 16'h0000, 64'h38, 64'h77, 64'h55);
    chk("R8 cas miss mem", mem[7], 64'h99);
    chk("R8 cas miss writes", 64'(wr_cnt), 64'd0);
    chk("R8 cas miss wb", c_data, 64'h99);
    mem[8] = 64'hAAAA_AAAA_0000_1234;
    run_op(8'hc3, 32'hf1, 16'h0000, 64'h40, 64'h5678, 64'hFFFF_FFFF_0000_1234);
    chk("R10 cas32 low compare", mem[8], 64'hAAAA_AAAA_0000_5678);
    chk("R10 cas32 wb", c_data, 64'h0000_0000_0000_1234);
  endtask

  task automatic t_illegal(input string tag, input logic [7:0] op, input logic [31:0] im);
    mem[10] = 64'h1234;
    run_op(op, im, 16'h0000, 64'h50, 64'h1, 64'h1234);
    chk({tag, " pulse"}, 64'(il_cnt), 64'd1);
    chk({tag, " latency"}, 64'(lat), 64'd1);
    chk({tag, " no access"}, 64'(rd_cnt + wr_cnt + dn_cnt), 64'd0);
    chk({tag, " mem"}, mem[10], 64'h1234);
  endtask

  task automatic t_busy_ignore;
    mem[9] = 64'd5;
    @(negedge clk);
    op_code = 8'hdb; imm = 32'h00; off = 16'h0; dst_val = 64'h48; src_val = 64'd3;
    rd_cnt = 0; wr_cnt = 0; dn_cnt = 0; il_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b1; imm = 32'he1; src_val = 64'h100;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 mem", mem[9], 64'd8);
    chk("R11 writes", 64'(wr_cnt), 64'd1);
    chk("R11 done count", 64'(dn_cnt), 64'd1);
    chk("R11 no illegal", 64'(il_cnt), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add64();
    t_logic();
    t_word32();
    t_xchg();
    t_cmpxchg();
    t_illegal("R2 byte", 8'hd3, 32'h01);
    t_illegal("R2 half", 8'hcb, 32'h01);
    t_illegal("R2 mode", 8'h7b, 32'h01);
    t_illegal("R9 xchg nofetch", 8'hdb, 32'he0);
    t_illegal("R9 cas nofetch", 8'hdb, 32'hf0);
    t_illegal("R9 code", 8'hdb, 32'h10);
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2ms;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule